// File: doc/BRIEF.md
# Wake-up Event Capture Unit

This block gathers the wake-up causes of a low-power controller and turns them into one wake request for the power sequencer. The causes are a bus line (a LIN receive level), a bank of monitor inputs, a bank of general-purpose pins and an internal cyclic timer. Every cause arrives as a plain digital level with no relation to the block clock. Each asynchronous level is synchronized and edge-detected, and an edge of the selected polarity counts as an event.

All causes have the same priority. The first event raises the wake request. Any event that comes later is still recorded in its own sticky flag, so software can read the full set of causes. Software clears flags with a write-one-to-clear vector. The power sequencer can drop the request with an acknowledge and keep the flags. The configuration (bus wake enable, per-input edge selects, cyclic enable) is loaded in one strobe. Its reset values arm the bus and monitor causes and leave the pin and cyclic causes off.

Top module: `wake_evt_capture`

## Requirements
- R1: A level change on an asynchronous input shows in `flags_o` and `wake_req_o` at the third rising clock edge after the change, and not earlier.
- R2: Each monitor and pin input has a 2-bit edge select: 00 no wake, 01 rising edge, 10 falling edge, 11 both edges.
- R3: The bus line wakes on a high-to-low transition only, and only while the bus wake enable is set. A low-to-high transition never sets its flag.
- R4: After reset, `flags_o` is zero and `wake_req_o` is low. The bus wake enable is on, every monitor select is 11, every pin select is 00 and the cyclic timer is off.
- R5: A flag stays set until software clears it. Events that arrive while a wake request is already pending still set their own flags.
- R6: A 1 in bit i of `clr_i` clears flag i at the next edge. An event for source i in the same cycle leaves flag i set.
- R7: `wake_req_o` rises with any event. It falls when `ack_i` is high or when all flags become clear. An event in the same cycle as `ack_i` keeps it high.
- R8: Pin events are ignored while `mode_i` is 10 (sleep). They are honoured in mode 01 (stop) and mode 00 (active).
- R9: With the cyclic enable set and `mode_i` not 00, the cyclic flag sets at the CYC_TICKS-th edge after the mode leaves 00. It never sets in mode 00.
- R10: Flag order: bit 0 is the bus line, bits 1..N_MON are the monitor inputs, the next N_GPIO bits are the pins, and the top bit is the cyclic timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low reset |
| mode_i | input | 2 | Power mode: 00 active, 01 stop, 10 sleep |
| lin_i | input | 1 | Asynchronous bus line level |
| mon_i | input | N_MON | Asynchronous monitor input levels |
| gpio_i | input | N_GPIO | Asynchronous pin levels |
| cfg_wr_i | input | 1 | Load strobe for all configuration fields |
| cfg_lin_en_i | input | 1 | Bus wake enable |
| cfg_mon_edge_i | input | 2*N_MON | Monitor edge selects, 2 bits per input |
| cfg_gpio_edge_i | input | 2*N_GPIO | Pin edge selects, 2 bits per input |
| cfg_cyc_en_i | input | 1 | Cyclic timer enable |
| clr_i | input | N_MON+N_GPIO+2 | Write-one-to-clear flag vector |
| ack_i | input | 1 | Power sequencer acknowledge |
| flags_o | output | N_MON+N_GPIO+2 | Sticky wake flags |
| wake_req_o | output | 1 | Wake request |

## Verification
The bench builds the block with five monitor inputs, three pins and CYC_TICKS set to 8. With these values every edge-select code sits on its own input in one configuration, and the cyclic period is short enough to count the edge at which the timer fires and the edge just before it. The default synchronizer depth of two keeps the three-edge latency that R1 names visible.

// File: rtl/wec_pkg.sv
package wec_pkg;
   localparam logic [1:0] MODE_ACTIVE = 2'b00;
   localparam logic [1:0] MODE_STOP   = 2'b01;
   localparam logic [1:0] MODE_SLEEP  = 2'b10;

   localparam logic [1:0] EDGE_OFF  = 2'b00;
   localparam logic [1:0] EDGE_RISE = 2'b01;
   localparam logic [1:0] EDGE_FALL = 2'b10;
   localparam logic [1:0] EDGE_BOTH = 2'b11;

   // sel[0] arms rising, sel[1] arms falling
   function automatic logic edge_hit(logic [1:0] sel, logic cur, logic prv);
      return (sel[0] & cur & ~prv) | (sel[1] & ~cur & prv);
   endfunction
endpackage

// File: rtl/wec_sync.sv
module wec_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o,
   output logic [W-1:0] prev_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wec_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];
   logic [W-1:0] prv_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
         prv_q <= '0;
      end else begin
         stg_q[0] <= async_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
         prv_q <= stg_q[STAGES-1];
      end
   end

   assign sync_o = stg_q[STAGES-1];
   assign prev_o = prv_q;
endmodule

// File: rtl/wec_edge_det.sv
module wec_edge_det
   import wec_pkg::*;
#(
   parameter int W = 1
) (
   input  logic [2*W-1:0] sel_i,
   input  logic [W-1:0]   cur_i,
   input  logic [W-1:0]   prv_i,
   input  logic           armed_i,
   output logic [W-1:0]   hit_o
);
   for (genvar g = 0; g < W; g++) begin : g_bit
      assign hit_o[g] = armed_i & edge_hit(sel_i[2*g +: 2], cur_i[g], prv_i[g]);
   end
endmodule

// File: rtl/wec_cyc_timer.sv
module wec_cyc_timer #(
   parameter int TICKS = 1000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic tick_o
);
   if (TICKS < 2) begin : g_bad_ticks
      $error("wec_cyc_timer: TICKS must be at least 2");
   end

   localparam int CW = $clog2(TICKS);
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   logic [CW-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (!run_i)  cnt_q <= '0;
      else if (tick_o)  cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/wec_flag_bank.sv
module wec_flag_bank #(
   parameter int N = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] clr_i,
   input  logic         ack_i,
   output logic [N-1:0] flags_o,
   output logic         req_o
);
   logic [N-1:0] flags_q, flags_d;
   logic         req_q, req_d;

   always_comb begin
      // event wins over a clear in the same cycle
      flags_d = (flags_q & ~clr_i) | evt_i;
      if (|evt_i)                         req_d = 1'b1;
      else if (ack_i || (flags_d == '0))  req_d = 1'b0;
      else                                req_d = req_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flags_q <= '0;
         req_q   <= 1'b0;
      end else begin
         flags_q <= flags_d;
         req_q   <= req_d;
      end
   end

   assign flags_o = flags_q;
   assign req_o   = req_q;
endmodule

// File: rtl/wake_evt_capture.sv
module wake_evt_capture
   import wec_pkg::*;
#(
   parameter int N_MON       = 5,
   parameter int N_GPIO      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int CYC_TICKS   = 1000
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [1:0]                mode_i,
   input  logic                      lin_i,
   input  logic [N_MON-1:0]          mon_i,
   input  logic [N_GPIO-1:0]         gpio_i,
   input  logic                      cfg_wr_i,
   input  logic                      cfg_lin_en_i,
   input  logic [2*N_MON-1:0]        cfg_mon_edge_i,
   input  logic [2*N_GPIO-1:0]       cfg_gpio_edge_i,
   input  logic                      cfg_cyc_en_i,
   input  logic [N_MON+N_GPIO+1:0]   clr_i,
   input  logic                      ack_i,
   output logic [N_MON+N_GPIO+1:0]   flags_o,
   output logic                      wake_req_o
);
   if (N_MON < 1 || N_GPIO < 1) begin : g_bad_counts
      $error("wake_evt_capture: N_MON and N_GPIO must be at least 1");
   end

   localparam int NASYNC = 1 + N_MON + N_GPIO;
   localparam int NSRC   = NASYNC + 1;

   // configuration with per-class reset defaults
   logic                lin_en_q;
   logic [2*N_MON-1:0]  mon_sel_q;
   logic [2*N_GPIO-1:0] gpio_sel_q;
   logic                cyc_en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lin_en_q   <= 1'b1;
         mon_sel_q  <= {N_MON{EDGE_BOTH}};
         gpio_sel_q <= {N_GPIO{EDGE_OFF}};
         cyc_en_q   <= 1'b0;
      end else if (cfg_wr_i) begin
         lin_en_q   <= cfg_lin_en_i;
         mon_sel_q  <= cfg_mon_edge_i;
         gpio_sel_q <= cfg_gpio_edge_i;
         cyc_en_q   <= cfg_cyc_en_i;
      end
   end

   // edges are masked until the synchronizer and history flop hold real samples
   logic [SYNC_STAGES:0] arm_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) arm_q <= '0;
      else         arm_q <= {arm_q[SYNC_STAGES-1:0], 1'b1};
   end

   logic [NASYNC-1:0]   raw, cur, prv, hit;
   logic [2*NASYNC-1:0] sel;
   logic [2*N_GPIO-1:0] gpio_sel_eff;
   logic [1:0]          lin_sel;

   assign raw          = {gpio_i, mon_i, lin_i};
   assign gpio_sel_eff = (mode_i == MODE_SLEEP) ? '0 : gpio_sel_q;
   assign lin_sel      = lin_en_q ? EDGE_FALL : EDGE_OFF;
   assign sel          = {gpio_sel_eff, mon_sel_q, lin_sel};

   wec_sync #(.W(NASYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (raw),
      .sync_o  (cur),
      .prev_o  (prv)
   );

   wec_edge_det #(.W(NASYNC)) u_edge (
      .sel_i   (sel),
      .cur_i   (cur),
      .prv_i   (prv),
      .armed_i (arm_q[SYNC_STAGES]),
      .hit_o   (hit)
   );

   logic cyc_tick;
   wec_cyc_timer #(.TICKS(CYC_TICKS)) u_cyc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (cyc_en_q && (mode_i != MODE_ACTIVE)),
      .tick_o (cyc_tick)
   );

   logic [NSRC-1:0] evt;
   assign evt = {cyc_tick, hit};

   wec_flag_bank #(.N(NSRC)) u_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt),
      .clr_i   (clr_i),
      .ack_i   (ack_i),
      .flags_o (flags_o),
      .req_o   (wake_req_o)
   );
endmodule

// File: rtl/wake_evt_capture_chk.sv
module wake_evt_capture_chk #(
   parameter int N_MON       = 5,
   parameter int N_GPIO      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int CYC_TICKS   = 1000
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic [1:0]              mode_i,
   input logic [N_MON+N_GPIO+1:0] clr_i,
   input logic [N_MON+N_GPIO+1:0] flags_o,
   input logic                    wake_req_o
);
   localparam int NSRC = N_MON + N_GPIO + 2;
   localparam logic [NSRC-1:0] GPIO_MASK = {1'b0, {N_GPIO{1'b1}}, {(N_MON+1){1'b0}}};

   // R5: a set flag only drops where a clear bit asked for it
   a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((($past(flags_o) & ~$past(clr_i)) & ~flags_o) == '0));

   // R7: a pending request always has a cause on record
   a_r7_req_has_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_req_o |-> (flags_o != '0));

   // R8: no pin flag newly sets from a sleep-mode cycle
   a_r8_gpio_quiet_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b10) |=> (((flags_o & ~$past(flags_o)) & GPIO_MASK) == '0));

   // R9: the cyclic flag never newly sets from an active-mode cycle
   a_r9_no_cyc_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b00) |=> !(flags_o[NSRC-1] && !$past(flags_o[NSRC-1])));
endmodule

bind wake_evt_capture wake_evt_capture_chk #(
   .N_MON(N_MON), .N_GPIO(N_GPIO), .SYNC_STAGES(SYNC_STAGES), .CYC_TICKS(CYC_TICKS)
) chk_i (.*);

// File: tb/wake_evt_capture_tb_top.sv
module wake_evt_capture_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NM = 5;
   localparam int NG = 3;
   localparam int NS = NM + NG + 2;
   localparam int TK = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic          lin = 1'b1;
   logic [NM-1:0] mon = '0;
   logic [NG-1:0] gpio = '0;
   logic          cfg_wr = 1'b0;
   logic          cfg_lin_en = 1'b1;
   logic [2*NM-1:0] cfg_mon = '0;
   logic [2*NG-1:0] cfg_gpio = '0;
   logic          cfg_cyc = 1'b0;
   logic [NS-1:0] clr = '0;
   logic          ack = 1'b0;
   logic [NS-1:0] flags;
   logic          req;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wake_evt_capture #(.N_MON(NM), .N_GPIO(NG), .SYNC_STAGES(2), .CYC_TICKS(TK)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .lin_i(lin), .mon_i(mon), .gpio_i(gpio),
      .cfg_wr_i(cfg_wr), .cfg_lin_en_i(cfg_lin_en), .cfg_mon_edge_i(cfg_mon),
      .cfg_gpio_edge_i(cfg_gpio), .cfg_cyc_en_i(cfg_cyc), .clr_i(clr), .ack_i(ack),
      .flags_o(flags), .wake_req_o(req)
   );

   // vector: mode(2) lin(1) mon(5) gpio(3) expected flags(10)
   localparam int NV = 18;
   localparam logic [20:0] VEC [NV] = '{
      {2'b00, 1'b1, 5'b00001, 3'b000, 10'h002},
      {2'b00, 1'b1, 5'b00000, 3'b000, 10'h000},
      {2'b00, 1'b1, 5'b00010, 3'b000, 10'h000},
      {2'b00, 1'b1, 5'b00000, 3'b000, 10'h004},
      {2'b00, 1'b1, 5'b00100, 3'b000, 10'h008},
      {2'b00, 1'b1, 5'b00000, 3'b000, 10'h008},
      {2'b00, 1'b1, 5'b01000, 3'b000, 10'h000},
      {2'b00, 1'b1, 5'b11000, 3'b000, 10'h020},
      {2'b00, 1'b1, 5'b00000, 3'b000, 10'h020},
      {2'b00, 1'b0, 5'b00000, 3'b000, 10'h001},
      {2'b00, 1'b1, 5'b00000, 3'b000, 10'h000},
      {2'b01, 1'b1, 5'b00000, 3'b001, 10'h040},
      {2'b01, 1'b1, 5'b00000, 3'b011, 10'h000},
      {2'b01, 1'b1, 5'b00000, 3'b000, 10'h080},
      {2'b01, 1'b1, 5'b00000, 3'b100, 10'h100},
      {2'b10, 1'b1, 5'b00000, 3'b000, 10'h000},
      {2'b00, 1'b0, 5'b00001, 3'b000, 10'h003},
      {2'b00, 1'b1, 5'b00000, 3'b000, 10'h000}
   };

   task automatic step(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic clear_all();
      clr = '1;
      step(1);
      clr = '0;
      step(1);
   endtask

   task automatic write_cfg(logic cyc_on);
      cfg_lin_en = 1'b1;
      // mon0 rise, mon1 fall, mon2 both, mon3 off, mon4 both
      cfg_mon  = {2'b11, 2'b00, 2'b11, 2'b10, 2'b01};
      // gpio0 rise, gpio1 fall, gpio2 both
      cfg_gpio = {2'b11, 2'b10, 2'b01};
      cfg_cyc  = cyc_on;
      cfg_wr   = 1'b1;
      step(1);
      cfg_wr   = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      step(5);
      rst_n = 1'b1;
      check("R4 flags after reset", 32'(flags), 32'h0);
      check("R4 req after reset", 32'(req), 32'h0);
      step(4);

      // R4 defaults: monitors wake on both edges, pins off, cyclic off
      mon = 5'b00001; step(3);
      check("R4 default monitor rise", 32'(flags), 32'h002);
      clear_all();
      mon = 5'b00000; step(3);
      check("R4 default monitor fall", 32'(flags), 32'h002);
      clear_all();
      gpio = 3'b001; step(3);
      check("R4 default pin off", 32'(flags), 32'h0);
      gpio = 3'b000; step(3);
      mode = 2'b01; step(20);
      check("R4 default cyclic off", 32'(flags), 32'h0);
      mode = 2'b00; step(1);

      // R1 latency and R3 bus falling edge
      lin = 1'b0; step(2);
      check("R1 no flag before third edge", 32'(flags), 32'h0);
      check("R1 no req before third edge", 32'(req), 32'h0);
      step(1);
      check("R1 flag at third edge", 32'(flags), 32'h001);
      check("R1 req at third edge", 32'(req), 32'h1);

      // R5 later event latched while pending
      mon = 5'b00001; step(3);
      check("R5 later event latched", 32'(flags), 32'h003);
      check("R5 req still high", 32'(req), 32'h1);

      // R7 acknowledge drops request and keeps flags
      ack = 1'b1; step(1); ack = 1'b0;
      check("R7 ack drops req", 32'(req), 32'h0);
      check("R7 ack keeps flags", 32'(flags), 32'h003);
      clr = 10'h001; step(1); clr = '0;
      check("R6 partial clear", 32'(flags), 32'h002);
      // event in the same cycle as ack
      mon = 5'b00000; step(2);
      ack = 1'b1; step(1); ack = 1'b0;
      check("R7 event with ack keeps req", 32'(req), 32'h1);
      lin = 1'b1; step(3);
      lin = 1'b0; step(3);
      check("R7 two flags pending", 32'(flags), 32'h003);
      clr = 10'h001; step(1); clr = '0;
      check("R7 req held with flag left", 32'(req), 32'h1);
      clr = 10'h002; step(1); clr = '0;
      check("R7 req drops when all clear", 32'(req), 32'h0);
      check("R6 all flags cleared", 32'(flags), 32'h0);
      lin = 1'b1; step(3);
      check("R3 rising bus edge ignored", 32'(flags), 32'h0);

      // R6 event coinciding with clear
      mon = 5'b00001; step(2);
      clr = 10'h002; step(1); clr = '0;
      check("R6 event beats clear", 32'(flags), 32'h002);
      mon = 5'b00000; step(3);
      clear_all();
      check("R6 clear empties flags", 32'(flags), 32'h0);

      // table walk: R2 edge codes, R3 bus, R8 pin gating, R10 bit order
      write_cfg(1'b0);
      for (int v = 0; v < NV; v++) begin
         mode = VEC[v][20:19];
         lin  = VEC[v][18];
         mon  = VEC[v][17:13];
         gpio = VEC[v][12:10];
         step(3);
         check($sformatf("R2/R3/R8/R10 vector %0d flags", v), 32'(flags), 32'(VEC[v][9:0]));
         check($sformatf("R7 vector %0d req", v), 32'(req), 32'(VEC[v][9:0] != 10'h0));
         clear_all();
      end

      // R9 cyclic timer
      write_cfg(1'b1);
      mode = 2'b00; step(30);
      check("R9 no cyclic in active", 32'(flags), 32'h0);
      mode = 2'b01; step(TK-1);
      check("R9 cyclic not yet", 32'(flags), 32'h0);
      step(1);
      check("R9 cyclic fires in stop", 32'(flags), 32'h200);
      mode = 2'b00;
      clear_all();
      mode = 2'b10; step(TK);
      check("R9 cyclic fires in sleep", 32'(flags), 32'h200);
      mode = 2'b00;
      clear_all();

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule